// File: doc/BRIEF.md
# Row Copy Authorization Controller

This block sits between a byte scratchpad and a main memory array. When a copy request arrives with a target address, it judges in one cycle whether the eight-byte scratchpad contents may be moved into the addressed row. The judgement combines four things: the scratchpad status (a partial-fill flag and the ending byte offset), the alignment of the target, its agreement with the address latched when the scratchpad was written, and the protection state. Protection comes as one byte per main-memory page plus a global copy-lock byte.

A refused request gives a one-cycle deny pulse and changes nothing. A granted request gives a one-cycle grant pulse, copies the scratchpad bytes at the moment of the grant, and then writes them as eight sequential byte strobes, lowest byte first. After the last byte it sets the copied flag, which tells the system that the scratchpad data now sits at the target. A new scratchpad write clears that flag.

The address space holds NUM_PAGES x ROWS_PER_PAGE main rows of 8 bytes. Above them come a register row, a user row and one reserved row. With the default parameters these are rows 0-15 (addresses 00h-7Fh), row 16 (80h-87h), row 17 (88h-8Fh) and row 18 (90h-97h). Any row above 18 is treated as reserved too. The row index is address bits [7:3], and the byte within the row is bits [2:0].

Top module: `rowcopy_ctrl`

## Requirements
- R1: A request is refused when sp_pf_i is 1 or sp_end_i is not 7.
- R2: A request is refused when copy_addr_i bits [2:0] are not 0 or copy_addr_i differs from sp_addr_i.
- R3: A page protection byte of 55h or AAh does not by itself refuse a copy to that page; page p covers main rows 4p..4p+3, and its byte is page_prot_i[8p+7:8p].
- R4: When copy_prot_i is 55h or AAh, copies to the register row (16) and the user row (17) are refused; otherwise they may be granted.
- R5: When copy_prot_i is 55h or AAh, copies to a main page whose protection byte is 55h are refused, while pages with other protection values stay copyable.
- R6: Copies to row 18 or above are always refused and never produce a write strobe.
- R7: The decision appears as exactly one of grant_o or deny_o, for one cycle, in the cycle after the request is sampled.
- R8: A granted copy holds busy_o and wr_en_o high for exactly 8 cycles. In those cycles wr_addr_o runs from the row base through base+7, and wr_data_o carries sp_data_i bits [8k+7:8k] for byte k, as sampled at the request edge.
- R9: aa_o is 1 from the cycle in which busy_o falls after a granted copy, and a pulse on sp_wr_i clears it in the following cycle.
- R10: A refused request produces no write strobe and leaves aa_o unchanged.
- R11: A request sampled while busy_o is 1 is ignored: no decision pulse, and the running copy is not altered.
- R12: During and right after reset, grant_o, deny_o, busy_o, wr_en_o and aa_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| copy_req_i | input | 1 | Copy request, one cycle |
| copy_addr_i | input | ADDR_W | Copy target address |
| sp_addr_i | input | ADDR_W | Address latched at scratchpad write |
| sp_pf_i | input | 1 | Scratchpad partial-fill flag |
| sp_end_i | input | 3 | Scratchpad ending byte offset |
| sp_wr_i | input | 1 | Scratchpad written pulse, clears aa_o |
| sp_data_i | input | 64 | Scratchpad contents, byte k at [8k+7:8k] |
| page_prot_i | input | NUM_PAGES*8 | Per-page protection bytes |
| copy_prot_i | input | 8 | Global copy-lock byte |
| grant_o | output | 1 | Copy granted pulse |
| deny_o | output | 1 | Copy refused pulse |
| busy_o | output | 1 | Copy sequence in progress |
| wr_en_o | output | 1 | Array byte write strobe |
| wr_addr_o | output | ADDR_W | Array byte address |
| wr_data_o | output | 8 | Array byte data |
| aa_o | output | 1 | Copied flag |

## Verification
The assertions assume that sp_wr_i is never pulsed in the last write cycle of a copy. Under that assumption the falling edge of busy_o always finds the copied flag set. They also assume that the protection and address inputs stay steady over the request edge. The bench drives every input on the falling clock edge and pulses sp_wr_i only between copies, never inside a sequence. Each randomized copy request gets a fresh set of inputs, and in the middle of some granted copies the bench raises a second request to exercise the busy case.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;
  localparam logic [7:0] PROT_LOCK = 8'h55;
  localparam logic [7:0] PROT_OTP  = 8'hAA;
  localparam int ROW_BYTES = 8;

  typedef enum logic [1:0] {
    ROW_MAIN = 2'd0,
    ROW_REG  = 2'd1,
    ROW_USER = 2'd2,
    ROW_RSV  = 2'd3
  } row_kind_e;

  function automatic logic lock_on(input logic [7:0] b);
    return (b == PROT_LOCK) || (b == PROT_OTP);
  endfunction
endpackage

// File: rtl/rowcopy_rules.sv
module rowcopy_rules
  import rowcopy_pkg::*;
#(
  parameter int NUM_PAGES     = 4,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ADDR_W        = 8
) (
  input  logic [ADDR_W-1:0]      copy_addr_i,
  input  logic [ADDR_W-1:0]      sp_addr_i,
  input  logic                   sp_pf_i,
  input  logic [2:0]             sp_end_i,
  input  logic [NUM_PAGES*8-1:0] page_prot_i,
  input  logic [7:0]             copy_prot_i,
  output logic                   allow_o
);
  localparam int ROW_W     = ADDR_W - 3;
  localparam int MAIN_ROWS = NUM_PAGES * ROWS_PER_PAGE;
  localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [7:0]       prot_arr [NUM_PAGES];
  logic [ROW_W-1:0] row;
  logic [PAGE_W-1:0] page_idx;
  row_kind_e        kind;
  logic [7:0]       page_prot;
  logic             sp_ok, addr_ok, lock;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_prot
    assign prot_arr[g] = page_prot_i[g*8 +: 8];
  end

  assign row = copy_addr_i[ADDR_W-1:3];

  always_comb begin
    if (row < ROW_W'(MAIN_ROWS))           kind = ROW_MAIN;
    else if (row == ROW_W'(MAIN_ROWS))     kind = ROW_REG;
    else if (row == ROW_W'(MAIN_ROWS + 1)) kind = ROW_USER;
    else                                   kind = ROW_RSV;
  end

  assign page_idx  = PAGE_W'(row / ROW_W'(ROWS_PER_PAGE));
  assign page_prot = (kind == ROW_MAIN) ? prot_arr[page_idx] : 8'h00;

  assign sp_ok   = !sp_pf_i && (sp_end_i == 3'd7);
  assign addr_ok = (copy_addr_i[2:0] == 3'd0) && (copy_addr_i == sp_addr_i);
  assign lock    = lock_on(copy_prot_i);

  always_comb begin
    allow_o = sp_ok && addr_ok;
    unique case (kind)
      ROW_RSV:           allow_o = 1'b0;
      ROW_REG, ROW_USER: if (lock) allow_o = 1'b0;
      ROW_MAIN:          if (lock && page_prot == PROT_LOCK) allow_o = 1'b0;
      default:           allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
  import rowcopy_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-4:0]   row_i,
  input  logic [63:0]         data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [7:0]          wr_data_o
);
  logic [2:0]        cnt_q;
  logic [ADDR_W-4:0] row_q;
  logic              busy_q;
  logic [7:0]        bytes_q [ROW_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= 3'd0;
      row_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= 3'd0;
      row_q  <= row_i;
    end else if (busy_q) begin
      if (cnt_q == 3'd7) busy_q <= 1'b0;
      cnt_q <= cnt_q + 3'd1;
    end
  end

  // snapshot so later scratchpad writes cannot leak into the copy
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bytes_q[b] <= 8'h00;
      else if (start_i) bytes_q[b] <= data_i[b*8 +: 8];
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && (cnt_q == 3'd7);
  assign wr_addr_o = {row_q, cnt_q};
  assign wr_data_o = bytes_q[cnt_q];
endmodule

// File: rtl/rowcopy_flag.sv
module rowcopy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/rowcopy_ctrl.sv
module rowcopy_ctrl
  import rowcopy_pkg::*;
#(
  parameter int NUM_PAGES     = 4,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ADDR_W        = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   copy_req_i,
  input  logic [ADDR_W-1:0]      copy_addr_i,
  input  logic [ADDR_W-1:0]      sp_addr_i,
  input  logic                   sp_pf_i,
  input  logic [2:0]             sp_end_i,
  input  logic                   sp_wr_i,
  input  logic [63:0]            sp_data_i,
  input  logic [NUM_PAGES*8-1:0] page_prot_i,
  input  logic [7:0]             copy_prot_i,
  output logic                   grant_o,
  output logic                   deny_o,
  output logic                   busy_o,
  output logic                   wr_en_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [7:0]             wr_data_o,
  output logic                   aa_o
);
  logic allow, take, start, done, busy;

  rowcopy_rules #(
    .NUM_PAGES    (NUM_PAGES),
    .ROWS_PER_PAGE(ROWS_PER_PAGE),
    .ADDR_W       (ADDR_W)
  ) u_rules (
    .copy_addr_i (copy_addr_i),
    .sp_addr_i   (sp_addr_i),
    .sp_pf_i     (sp_pf_i),
    .sp_end_i    (sp_end_i),
    .page_prot_i (page_prot_i),
    .copy_prot_i (copy_prot_i),
    .allow_o     (allow)
  );

  // requests during a running copy are dropped
  assign take  = copy_req_i && !busy;
  assign start = take && allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= start;
      deny_o  <= take && !allow;
    end
  end

  rowcopy_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .row_i     (copy_addr_i[ADDR_W-1:3]),
    .data_i    (sp_data_i),
    .busy_o    (busy),
    .done_o    (done),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  rowcopy_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done),
    .clr_i  (sp_wr_i),
    .flag_o (aa_o)
  );

  assign busy_o  = busy;
  assign wr_en_o = busy;
endmodule

// File: rtl/rowcopy_ctrl_chk.sv
module rowcopy_ctrl_chk #(
  parameter int NUM_PAGES     = 4,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ADDR_W        = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              copy_req_i,
  input logic              sp_pf_i,
  input logic [2:0]        sp_end_i,
  input logic              grant_o,
  input logic              deny_o,
  input logic              busy_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              aa_o
);
  localparam int ROW_W   = ADDR_W - 3;
  localparam int RSV_ROW = NUM_PAGES * ROWS_PER_PAGE + 2;

  assert_sp_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(!sp_pf_i && sp_end_i == 3'd7));

  assert_reserved_untouched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o[ADDR_W-1:3] < ROW_W'(RSV_ROW));

  assert_single_decision_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, deny_o}));

  assert_decision_follows_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || deny_o) |-> ($past(copy_req_i) && !$past(busy_o)));

  assert_grant_starts_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (busy_o && wr_en_o && wr_addr_o[2:0] == 3'd0));

  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_addr_o == $past(wr_addr_o) + ADDR_W'(1));

  assert_strobe_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o == busy_o);

  assert_aa_on_finish_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> aa_o);

  assert_deny_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> (!wr_en_o && !busy_o));

  assert_busy_ignores_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> (!grant_o && !deny_o));
endmodule

bind rowcopy_ctrl rowcopy_ctrl_chk #(
  .NUM_PAGES    (NUM_PAGES),
  .ROWS_PER_PAGE(ROWS_PER_PAGE),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .copy_req_i (copy_req_i),
  .sp_pf_i    (sp_pf_i),
  .sp_end_i   (sp_end_i),
  .grant_o    (grant_o),
  .deny_o     (deny_o),
  .busy_o     (busy_o),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .aa_o       (aa_o)
);

// File: tb/rowcopy_ctrl_test.sv
`timescale 1ns/1ps
module rowcopy_ctrl_test;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        copy_req_i = 1'b0;
  logic [7:0]  copy_addr_i = '0, sp_addr_i = '0;
  logic        sp_pf_i = 1'b0;
  logic [2:0]  sp_end_i = '0;
  logic        sp_wr_i = 1'b0;
  logic [63:0] sp_data_i = '0;
  logic [31:0] page_prot_i = '0;
  logic [7:0]  copy_prot_i = '0;
  logic        grant_o, deny_o, busy_o, wr_en_o, aa_o;
  logic [7:0]  wr_addr_o, wr_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit aa_exp = 1'b0;

  always #5 clk = ~clk;

  rowcopy_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .copy_req_i(copy_req_i),
    .copy_addr_i(copy_addr_i), .sp_addr_i(sp_addr_i), .sp_pf_i(sp_pf_i),
    .sp_end_i(sp_end_i), .sp_wr_i(sp_wr_i), .sp_data_i(sp_data_i),
    .page_prot_i(page_prot_i), .copy_prot_i(copy_prot_i),
    .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .aa_o(aa_o)
  );

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit exp_allow(input logic [7:0] ca, input logic [7:0] sa, input bit pf,
                                   input logic [2:0] e, input logic [31:0] pp, input logic [7:0] cp);
    int row = int'(ca[7:3]);
    bit lk = (cp == 8'h55) || (cp == 8'hAA);
    logic [7:0] pb;
    if (pf || e != 3'd7) return 1'b0;
    if (ca[2:0] != 3'd0 || ca != sa) return 1'b0;
    if (row >= 18) return 1'b0;
    if (row == 16 || row == 17) return !lk;
    pb = pp[(row / 4) * 8 +: 8];
    if (lk && pb == 8'h55) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_copy(input logic [7:0] ca, input logic [7:0] sa, input bit pf,
                          input logic [2:0] e, input logic [31:0] pp, input logic [7:0] cp,
                          input logic [63:0] d, input string rq, input bit poke);
    bit g = exp_allow(ca, sa, pf, e, pp, cp);
    @(negedge clk);
    copy_addr_i = ca; sp_addr_i = sa; sp_pf_i = pf; sp_end_i = e;
    page_prot_i = pp; copy_prot_i = cp; sp_data_i = d; copy_req_i = 1'b1;
    @(negedge clk);
    copy_req_i = 1'b0;
    sp_data_i = {$urandom, $urandom};
    check(grant_o == g, {rq, " R7 grant"}, 64'(grant_o), 64'(g));
    check(deny_o == !g, {rq, " R7 deny"}, 64'(deny_o), 64'(!g));
    if (g) begin
      for (int k = 0; k < 8; k++) begin
        check(wr_en_o && busy_o, "R8 strobe", 64'(wr_en_o), 64'h1);
        check(wr_addr_o == {ca[7:3], 3'(k)}, "R8 addr", 64'(wr_addr_o), 64'({ca[7:3], 3'(k)}));
        check(wr_data_o == d[k*8 +: 8], "R8 data", 64'(wr_data_o), 64'(d[k*8 +: 8]));
        if (k > 0) check(!grant_o && !deny_o, "R11 no decision while busy",
                         64'({grant_o, deny_o}), 64'h0);
        if (poke && k == 2) copy_req_i = 1'b1;
        if (k == 3) copy_req_i = 1'b0;
        @(negedge clk);
      end
      check(!busy_o && !wr_en_o, "R8 eight cycles", 64'(busy_o), 64'h0);
      check(aa_o == 1'b1, "R9 aa set", 64'(aa_o), 64'h1);
      aa_exp = 1'b1;
    end else begin
      check(!wr_en_o, "R10 no write", 64'(wr_en_o), 64'h0);
      check(aa_o == aa_exp, "R10 aa kept", 64'(aa_o), 64'(aa_exp));
      if (ca[7:3] >= 5'd18) check(!wr_en_o, "R6 reserved", 64'(wr_en_o), 64'h0);
      @(negedge clk);
      check(!deny_o && !wr_en_o, "R7 one-cycle deny", 64'({deny_o, wr_en_o}), 64'h0);
    end
  endtask

  task automatic clear_aa();
    @(negedge clk); sp_wr_i = 1'b1;
    @(negedge clk); sp_wr_i = 1'b0;
    check(aa_o == 1'b0, "R9 aa cleared", 64'(aa_o), 64'h0);
    aa_exp = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] dd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check({grant_o, deny_o, busy_o, wr_en_o, aa_o} == 5'b0, "R12 in reset",
          64'({grant_o, deny_o, busy_o, wr_en_o, aa_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({grant_o, deny_o, busy_o, wr_en_o, aa_o} == 5'b0, "R12 after reset",
          64'({grant_o, deny_o, busy_o, wr_en_o, aa_o}), 64'h0);

    dd = 64'h8877_6655_4433_2211;
    run_copy(8'h00, 8'h00, 0, 3'd7, 32'h0, 8'h00, dd, "R8 basic", 0);
    run_copy(8'h08, 8'h08, 1, 3'd7, 32'h0, 8'h00, dd, "R1 pf", 0);
    run_copy(8'h08, 8'h08, 0, 3'd6, 32'h0, 8'h00, dd, "R1 end", 0);
    clear_aa();
    run_copy(8'h0B, 8'h0B, 0, 3'd7, 32'h0, 8'h00, dd, "R2 align", 0);
    run_copy(8'h10, 8'h18, 0, 3'd7, 32'h0, 8'h00, dd, "R2 mismatch", 0);
    run_copy(8'h20, 8'h20, 0, 3'd7, 32'h0000_5500, 8'h00, 64'hDEAD_BEEF_0BAD_F00D, "R3 refresh", 0);
    clear_aa();
    run_copy(8'h48, 8'h48, 0, 3'd7, 32'h00AA_0000, 8'h12, dd, "R3 otp page", 0);
    run_copy(8'h80, 8'h80, 0, 3'd7, 32'h0, 8'h55, dd, "R4 reg row", 0);
    run_copy(8'h88, 8'h88, 0, 3'd7, 32'h0, 8'hAA, dd, "R4 user row", 0);
    run_copy(8'h80, 8'h80, 0, 3'd7, 32'h0, 8'h00, dd, "R4 reg open", 0);
    clear_aa();
    run_copy(8'h60, 8'h60, 0, 3'd7, 32'h5500_0000, 8'hAA, dd, "R5 locked page", 0);
    run_copy(8'h60, 8'h60, 0, 3'd7, 32'hAA00_0000, 8'h55, dd, "R5 otp page", 0);
    run_copy(8'h90, 8'h90, 0, 3'd7, 32'h0, 8'h00, dd, "R6 reserved", 0);
    run_copy(8'h98, 8'h98, 0, 3'd7, 32'h0, 8'h00, dd, "R6 above", 0);
    run_copy(8'h38, 8'h38, 0, 3'd7, 32'h0, 8'h00, 64'h0102_0304_0506_0708, "R11 poke", 1);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] ca, sa, cp;
      logic [31:0] pp;
      logic [2:0] e;
      bit pf;
      ca = {5'($urandom_range(0, 19)), 3'b000};
      if ($urandom_range(0, 7) == 0) ca[2:0] = 3'($urandom);
      sa = ($urandom_range(0, 7) == 0) ? 8'($urandom) : ca;
      pf = ($urandom_range(0, 7) == 0);
      e  = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'd7;
      for (int p = 0; p < NP; p++) begin
        case ($urandom_range(0, 3))
          0: pp[p*8 +: 8] = 8'h55;
          1: pp[p*8 +: 8] = 8'hAA;
          2: pp[p*8 +: 8] = 8'h00;
          default: pp[p*8 +: 8] = 8'($urandom);
        endcase
      end
      case ($urandom_range(0, 3))
        0: cp = 8'h55;
        1: cp = 8'hAA;
        2: cp = 8'h00;
        default: cp = 8'hFF;
      endcase
      if ($urandom_range(0, 3) == 0) clear_aa();
      run_copy(ca, sa, pf, e, pp, cp, {$urandom, $urandom}, "rand", $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule